// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip that carries boundary scan. A 16-state controller follows the test mode select line on each rising edge of the test clock. A 4-bit instruction, applied on the falling edge, chooses one of three scan paths between serial input and serial output: a single bypass cell, a fixed 32-bit identification word, or a chain of boundary cells. The boundary chain covers a configurable number of pad inputs and core outputs. The same instruction also sets three static pad controls: tri-state all outputs, drive the outputs from the boundary cells, and enable pad capture.

Test equipment uses the standard shift protocol. It loads an instruction through the instruction path and then scans data through the selected register. In Update-DR, the output half of the boundary chain is copied into a holding stage, which can then drive the pads. The pad cells and the core are not part of this block. They appear only as plain input and output vectors.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: The controller state moves on the rising edge of `tck` along the standard 16-state diagram, Pause and Exit2 states included. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state.
- R2: If `trst_n` is low at a rising edge of `tck`, or the controller is in Test-Logic-Reset, the active instruction becomes 0010 (identification). When `HAS_ID` is 0 it becomes 1111 (bypass) instead. This clears `pad_highz`, `pad_drive` and `pad_sample`. A low `trst_n` also clears `bsr_out`.
- R3: In Capture-IR the instruction shift register loads 1101. The first four bits shifted out on `tdo` are therefore 1, 0, 1, 1.
- R4: The active instruction changes only on the falling edge of `tck` in Update-IR, or on reset. Shifting a new opcode and holding in Exit1-IR, Pause-IR or Exit2-IR leaves the pad controls unchanged.
- R5: Opcodes 0000 and 0001 select the boundary chain, which is `N_IN+N_OUT` cells long. Opcode 0010 selects the 32-bit identification register when `HAS_ID` is 1. Every other opcode, including 1101, selects the 1-bit bypass register. Opcodes are shifted in LSB first.
- R6: The identification register captures {4'h2, part code, 11'h033, 1'b1}. The part code is 16'h0208, or 16'h020A when `PART_ALT` is 1. It is shifted out LSB first.
- R7: The bypass register captures 0 in Capture-DR. After that, bypass data appears on `tdo` delayed by exactly one shift.
- R8: In Capture-DR with the boundary chain selected, cells [N_IN-1:0] load `pad_in` and cells [N_IN+N_OUT-1:N_IN] load `core_out`. Cell 0 is nearest `tdo`. In Update-DR, `bsr_out` takes cells [N_IN+N_OUT-1:N_IN], but only while the boundary chain is selected.
- R9: `pad_drive` is 1 for opcodes 0000 and 1000. `pad_highz` is 1 only for opcode 0011. `pad_sample` is 1 for opcodes 0000 and 0001. All three are 0 for every other opcode.
- R10: `tdo` and `tdo_oe` change on the falling edge of `tck`. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset, sampled on rising `tck` |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in, sampled on rising `tck` |
| tdo | output | 1 | Serial test data out, valid when `tdo_oe` is 1 |
| tdo_oe | output | 1 | Output enable for `tdo` |
| pad_in | input | N_IN | Pad input values offered to the boundary chain |
| core_out | input | N_OUT | Core output values offered to the boundary chain |
| bsr_out | output | N_OUT | Boundary holding stage that drives the output pads |
| pad_highz | output | 1 | Tri-state every output pad |
| pad_drive | output | 1 | Drive output pads from `bsr_out` |
| pad_sample | output | 1 | Pad capture into the boundary chain is enabled |

## Verification
The hardest case to reach from the ports is showing that the pad controls hold while a new opcode sits fully shifted but not yet updated. Test-Logic-Reset would clear everything, so it cannot be used to get there. The stimulus shifts a tri-state opcode and then leaves Shift-IR through Exit1-IR into Pause-IR. It stays in Pause-IR for several clocks, then passes Exit2-IR, and checks the controls at each stop before Update-IR. A second hard case is reaching reset through `tms` alone from the middle of a data shift. Here the bench counts the five edges and checks that the controls still hold after the fourth.

// File: rtl/jtag_tap_pkg.sv
`timescale 1ns/1ps
// Package jtag_tap_pkg
// Shared types and functions for the test access port: controller states,
// scan path selector, opcode constants, the state transition function and
// the instruction decoder. Assumes a 4-bit instruction register.
package jtag_tap_pkg;

    localparam int IR_W = 4;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        TLR, RTI,
        SEL_DR, CAP_DR, SHF_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SHF_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] {
        PATH_BYP,
        PATH_ID,
        PATH_BSR
    } dr_path_t;

    localparam logic [IR_W-1:0] OP_EXTEST   = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 4'b0001;
    localparam logic [IR_W-1:0] OP_IDCODE   = 4'b0010;
    localparam logic [IR_W-1:0] OP_HIGHZ    = 4'b0011;
    localparam logic [IR_W-1:0] OP_CLAMP    = 4'b1000;
    localparam logic [IR_W-1:0] OP_BYPASS   = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b1101;

    typedef struct packed {
        dr_path_t path;
        logic     drive;
        logic     highz;
        logic     sample;
    } ir_decode_t;

    // Next controller state for a given current state and TMS value.
    function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
        tap_state_t n;
        case (s)
            TLR:     n = m ? TLR    : RTI;
            RTI:     n = m ? SEL_DR : RTI;
            SEL_DR:  n = m ? SEL_IR : CAP_DR;
            CAP_DR:  n = m ? EX1_DR : SHF_DR;
            SHF_DR:  n = m ? EX1_DR : SHF_DR;
            EX1_DR:  n = m ? UPD_DR : PAU_DR;
            PAU_DR:  n = m ? EX2_DR : PAU_DR;
            EX2_DR:  n = m ? UPD_DR : SHF_DR;
            UPD_DR:  n = m ? SEL_DR : RTI;
            SEL_IR:  n = m ? TLR    : CAP_IR;
            CAP_IR:  n = m ? EX1_IR : SHF_IR;
            SHF_IR:  n = m ? EX1_IR : SHF_IR;
            EX1_IR:  n = m ? UPD_IR : PAU_IR;
            PAU_IR:  n = m ? EX2_IR : PAU_IR;
            EX2_IR:  n = m ? UPD_IR : SHF_IR;
            UPD_IR:  n = m ? SEL_DR : RTI;
            default: n = TLR;
        endcase
        return n;
    endfunction

    // Map an active opcode onto its scan path and pad controls.
    function automatic ir_decode_t decode_op(input logic [IR_W-1:0] op, input bit has_id);
        ir_decode_t d;
        d = '{path: PATH_BYP, drive: 1'b0, highz: 1'b0, sample: 1'b0};
        case (op)
            OP_EXTEST: begin
                d.path   = PATH_BSR;
                d.drive  = 1'b1;
                d.sample = 1'b1;
            end
            OP_SAMPLE: begin
                d.path   = PATH_BSR;
                d.sample = 1'b1;
            end
            OP_IDCODE: d.path  = has_id ? PATH_ID : PATH_BYP;
            OP_HIGHZ:  d.highz = 1'b1;
            OP_CLAMP:  d.drive = 1'b1;
            default:   d.path  = PATH_BYP;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
`timescale 1ns/1ps
// Module jtag_tap_fsm
// The 16-state controller. It advances on the rising edge of tck from tms.
// A synchronous active-low reset forces Test-Logic-Reset.
// Assumes tms is stable around the rising edge.
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state
);

    // Controller state register.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= TLR;
        else         state <= tap_next(state, tms);
    end

endmodule

// File: rtl/jtag_tap_ir.sv
`timescale 1ns/1ps
// Module jtag_tap_ir
// Instruction shift stage and active instruction. The shift stage captures a
// fixed pattern and shifts LSB first on rising tck. The active instruction is
// loaded on falling tck in Update-IR, and is reset in Test-Logic-Reset or when
// trst_n is low. Assumes the controller state comes from jtag_tap_fsm.
module jtag_tap_ir
    import jtag_tap_pkg::*;
#(
    parameter bit HAS_ID = 1'b1
) (
    input  logic             tck,
    input  logic             trst_n,
    input  tap_state_t       state,
    input  logic             tdi,
    output logic [IR_W-1:0]  ir_shift,
    output logic [IR_W-1:0]  active_op
);

    localparam logic [IR_W-1:0] RESET_OP = HAS_ID ? OP_IDCODE : OP_BYPASS;

    // Capture and shift of the instruction path.
    always_ff @(posedge tck) begin
        if (!trst_n)               ir_shift <= IR_CAPTURE;
        else if (state == CAP_IR)  ir_shift <= IR_CAPTURE;
        else if (state == SHF_IR)  ir_shift <= {tdi, ir_shift[IR_W-1:1]};
    end

    // Active instruction: falling-edge update and reset load.
    always_ff @(negedge tck) begin
        if (!trst_n || state == TLR) active_op <= RESET_OP;
        else if (state == UPD_IR)    active_op <= ir_shift;
    end

endmodule

// File: rtl/jtag_tap_dr.sv
`timescale 1ns/1ps
// Module jtag_tap_dr
// Data registers: bypass cell, optional identification register, and the
// boundary chain with its output holding stage. Only the selected path
// captures, shifts or updates. Cell 0 of every path is nearest tdo.
// Assumes path is stable except across Update-IR.
module jtag_tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int N_IN     = 4,
    parameter int N_OUT    = 4,
    parameter bit HAS_ID   = 1'b1,
    parameter bit PART_ALT = 1'b0
) (
    input  logic             tck,
    input  logic             trst_n,
    input  tap_state_t       state,
    input  dr_path_t         path,
    input  logic             tdi,
    input  logic [N_IN-1:0]  pad_in,
    input  logic [N_OUT-1:0] core_out,
    output logic             dr_tdo,
    output logic [N_OUT-1:0] bsr_out
);

    localparam int BSR_LEN = N_IN + N_OUT;
    localparam logic [15:0]   PART_CODE = PART_ALT ? 16'h020A : 16'h0208;
    localparam logic [ID_W-1:0] ID_WORD = {4'h2, PART_CODE, 11'h033, 1'b1};

    logic               byp_q;
    logic               id_lsb;
    logic [BSR_LEN-1:0] bsr_q;

    // Bypass cell: captures 0, shifts one bit.
    always_ff @(posedge tck) begin
        if (!trst_n)                                  byp_q <= 1'b0;
        else if (path == PATH_BYP && state == CAP_DR) byp_q <= 1'b0;
        else if (path == PATH_BYP && state == SHF_DR) byp_q <= tdi;
    end

    generate
        if (HAS_ID) begin : g_id
            logic [ID_W-1:0] id_q;
            // Identification register: loads the fixed word, shifts LSB first.
            always_ff @(posedge tck) begin
                if (!trst_n)                                 id_q <= ID_WORD;
                else if (path == PATH_ID && state == CAP_DR) id_q <= ID_WORD;
                else if (path == PATH_ID && state == SHF_DR) id_q <= {tdi, id_q[ID_W-1:1]};
            end
            assign id_lsb = id_q[0];
        end else begin : g_no_id
            assign id_lsb = 1'b0;
        end
    endgenerate

    // Boundary chain: snapshot of pads and core outputs, then serial shift.
    always_ff @(posedge tck) begin
        if (!trst_n)                                  bsr_q <= '0;
        else if (path == PATH_BSR && state == CAP_DR) bsr_q <= {core_out, pad_in};
        else if (path == PATH_BSR && state == SHF_DR) bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
    end

    // Output holding stage: copies the output cells on falling tck in Update-DR.
    always_ff @(negedge tck) begin
        if (!trst_n)                                  bsr_out <= '0;
        else if (path == PATH_BSR && state == UPD_DR) bsr_out <= bsr_q[BSR_LEN-1:N_IN];
    end

    // Serial output of the selected path.
    always_comb begin
        case (path)
            PATH_ID:  dr_tdo = id_lsb;
            PATH_BSR: dr_tdo = bsr_q[0];
            default:  dr_tdo = byp_q;
        endcase
    end

endmodule

// File: rtl/jtag_tap_ctrl.sv
`timescale 1ns/1ps
// Module jtag_tap_ctrl
// Top of the test access port. Ties together the controller, the instruction
// stage and the data registers, decodes the active instruction into the path
// select and pad controls, and retimes tdo and its enable onto falling tck.
// Assumes a free-running tck while trst_n is low, so that reset is taken.
module jtag_tap_ctrl
    import jtag_tap_pkg::*;
#(
    parameter int N_IN     = 4,
    parameter int N_OUT    = 4,
    parameter bit HAS_ID   = 1'b1,
    parameter bit PART_ALT = 1'b0
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_oe,
    input  logic [N_IN-1:0]  pad_in,
    input  logic [N_OUT-1:0] core_out,
    output logic [N_OUT-1:0] bsr_out,
    output logic             pad_highz,
    output logic             pad_drive,
    output logic             pad_sample
);

    tap_state_t      state;
    logic [IR_W-1:0] ir_shift;
    logic [IR_W-1:0] active_op;
    ir_decode_t      dec;
    logic            dr_tdo;

    jtag_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    jtag_tap_ir #(.HAS_ID(HAS_ID)) u_ir (
        .tck       (tck),
        .trst_n    (trst_n),
        .state     (state),
        .tdi       (tdi),
        .ir_shift  (ir_shift),
        .active_op (active_op)
    );

    // Decode of the active instruction; it changes only when active_op does.
    always_comb dec = decode_op(active_op, HAS_ID);

    assign pad_drive  = dec.drive;
    assign pad_highz  = dec.highz;
    assign pad_sample = dec.sample;

    jtag_tap_dr #(
        .N_IN     (N_IN),
        .N_OUT    (N_OUT),
        .HAS_ID   (HAS_ID),
        .PART_ALT (PART_ALT)
    ) u_dr (
        .tck      (tck),
        .trst_n   (trst_n),
        .state    (state),
        .path     (dec.path),
        .tdi      (tdi),
        .pad_in   (pad_in),
        .core_out (core_out),
        .dr_tdo   (dr_tdo),
        .bsr_out  (bsr_out)
    );

    // Serial output and its enable, retimed onto falling tck.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= (state == SHF_IR) ? ir_shift[0] : dr_tdo;
            tdo_oe <= (state == SHF_IR) || (state == SHF_DR);
        end
    end

endmodule

// File: rtl/jtag_tap_ctrl_chk.sv
`timescale 1ns/1ps
// Module jtag_tap_ctrl_chk
// Property checker bound into jtag_tap_ctrl. It observes the controller state,
// the instruction stage and the pad controls on rising tck.
module jtag_tap_ctrl_chk
    import jtag_tap_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input tap_state_t      state,
    input logic [IR_W-1:0] ir_shift,
    input logic [IR_W-1:0] active_op,
    input logic            tdo_oe,
    input logic            pad_highz,
    input logic            pad_drive,
    input logic            pad_sample
);

    // R10
    tdo_oe_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == SHF_IR || state == SHF_DR));

    // R3
    ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == SHF_IR && $past(state) == CAP_IR) |-> (ir_shift[1:0] == 2'b01));

    // R4
    ctrl_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable({pad_highz, pad_drive, pad_sample}) |-> (state == UPD_IR || state == TLR));

    // R4
    op_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(active_op) |-> (state == UPD_IR || state == TLR));

    // R2
    reset_op_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TLR) |=> (active_op == OP_IDCODE || active_op == OP_BYPASS));

    // R9
    highz_excl_chk: assert property (@(posedge tck) disable iff (!trst_n)
        pad_highz |-> !(pad_drive || pad_sample));

endmodule

bind jtag_tap_ctrl jtag_tap_ctrl_chk u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .state      (state),
    .ir_shift   (ir_shift),
    .active_op  (active_op),
    .tdo_oe     (tdo_oe),
    .pad_highz  (pad_highz),
    .pad_drive  (pad_drive),
    .pad_sample (pad_sample)
);

// File: tb/jtag_tap_ctrl_bench.sv
`timescale 1ns/1ps
// Bench for jtag_tap_ctrl. It sweeps all 16 opcodes, computes the expected
// scan output and pad controls from the requirements, and exercises the
// pause path, reset through tms and reset through trst_n.
module jtag_tap_ctrl_bench;

    localparam int N_IN  = 4;
    localparam int N_OUT = 4;
    localparam int NB    = N_IN + N_OUT;
    localparam int DRN   = 40;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic [N_IN-1:0]  pad_in = '0;
    logic [N_OUT-1:0] core_out = '0;
    logic             tdo, tdo_oe, pad_highz, pad_drive, pad_sample;
    logic [N_OUT-1:0] bsr_out;

    int checks = 0;
    int errors = 0;
    logic [N_OUT-1:0] exp_bsr = '0;

    always #2.5 tck = ~tck;

    jtag_tap_ctrl #(.N_IN(N_IN), .N_OUT(N_OUT), .HAS_ID(1'b1), .PART_ALT(1'b0)) u_jtag_tap_ctrl (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .pad_in(pad_in), .core_out(core_out), .bsr_out(bsr_out),
        .pad_highz(pad_highz), .pad_drive(pad_drive), .pad_sample(pad_sample)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock: drive tms/tdi, pass rising then falling edge, sample tdo after.
    task automatic step(input logic m, input logic d, output logic o);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
        o = tdo;
    endtask

    // Full scan from Run-Test/Idle back to Run-Test/Idle.
    task automatic scan(input bit ir, input int n, input logic [63:0] din,
                        output logic [63:0] dout, output bit oe_ok);
        logic o;
        dout  = '0;
        oe_ok = 1'b1;
        step(1'b1, 1'b0, o);
        if (ir) step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        dout[0] = o;
        for (int i = 0; i < n; i++) begin
            if (tdo_oe !== 1'b1) oe_ok = 1'b0;
            step(i == n - 1, din[i], o);
            if (i < n - 1) dout[i+1] = o;
        end
        if (tdo_oe !== 1'b0) oe_ok = 1'b0;
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    // Expected path length from the opcode table of R5.
    function automatic int exp_len(input logic [3:0] op);
        if (op == 4'd0 || op == 4'd1) return NB;
        if (op == 4'd2) return 32;
        return 1;
    endfunction

    // Expected captured value from R6, R7 and R8.
    function automatic logic [63:0] exp_cap(input logic [3:0] op);
        logic [63:0] v;
        if (op == 4'd0 || op == 4'd1)
            v = 64'(pad_in) + (64'(core_out) << N_IN);
        else if (op == 4'd2)
            v = (64'd2 << 28) + (64'h0208 << 12) + (64'h33 << 1) + 64'd1;
        else
            v = 64'd0;
        return v;
    endfunction

    // Expected scan-out sequence for a DRN-bit data scan.
    function automatic logic [63:0] exp_scan(input logic [3:0] op, input logic [63:0] din);
        logic [63:0] cap, r;
        int l;
        cap = exp_cap(op);
        l = exp_len(op);
        r = '0;
        for (int k = 0; k < DRN; k++) r[k] = (k < l) ? cap[k] : din[k-l];
        return r;
    endfunction

    initial begin : watchdog
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [63:0] dout, din, e;
        bit oe_ok;
        logic o;
        logic [3:0] op;

        repeat (3) @(negedge tck);
        #1;
        // R2: reset state at the ports
        chk("R2 controls after trst_n", {61'd0, pad_highz, pad_drive, pad_sample}, 64'd0);
        chk("R2 bsr_out after trst_n", 64'(bsr_out), 64'd0);
        chk("R10 tdo_oe in reset", 64'(tdo_oe), 64'd0);
        trst_n = 1'b1;
        step(1'b0, 1'b0, o);

        // R2 R6: reset instruction selects identification
        din = 64'hA5A5_5A5A_F00F;
        scan(1'b0, DRN, din, dout, oe_ok);
        chk("R6 identification after reset", dout & ((64'd1 << DRN) - 1), exp_scan(4'd2, din));
        chk("R10 tdo_oe during shift", 64'(oe_ok), 64'd1);

        // R3 R5 R6 R7 R8 R9: sweep every opcode
        for (int k = 0; k < 16; k++) begin
            op = 4'(k);
            pad_in   = N_IN'(k * 5 + 3);
            core_out = N_OUT'(k * 3 + 9);
            scan(1'b1, 4, 64'(op), dout, oe_ok);
            chk("R3 capture-IR pattern", dout[3:0], 64'hD);
            chk("R10 tdo_oe in IR shift", 64'(oe_ok), 64'd1);
            chk("R9 pad_drive", 64'(pad_drive), 64'(op == 4'd0 || op == 4'd8));
            chk("R9 pad_highz", 64'(pad_highz), 64'(op == 4'd3));
            chk("R9 pad_sample", 64'(pad_sample), 64'(op == 4'd0 || op == 4'd1));
            din = {24'd0, 8'(k * 37 + 1), 32'(k * 32'h1357_9BDF + 32'h2468)};
            scan(1'b0, DRN, din, dout, oe_ok);
            chk("R5 R7 R8 data path", dout & ((64'd1 << DRN) - 1), exp_scan(op, din));
            if (op == 4'd0 || op == 4'd1)
                for (int j = 0; j < N_OUT; j++) exp_bsr[j] = din[DRN - NB + N_IN + j];
            chk("R8 bsr_out update", 64'(bsr_out), 64'(exp_bsr));
            chk("R4 controls hold over DR scan", {61'd0, pad_highz, pad_drive, pad_sample},
                {61'd0, op == 4'd3, op == 4'd0 || op == 4'd8, op == 4'd0 || op == 4'd1});
        end

        // R4: high-Z opcode held in Pause-IR does not act until Update-IR
        step(1'b1, 1'b0, o);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        for (int i = 0; i < 4; i++) step(i == 3, OP_HIGHZ_BIT(i), o);
        chk("R4 highz still off in Exit1-IR", 64'(pad_highz), 64'd0);
        repeat (3) step(1'b0, 1'b0, o);
        chk("R4 highz still off in Pause-IR", 64'(pad_highz), 64'd0);
        step(1'b1, 1'b0, o);
        chk("R4 highz still off in Exit2-IR", 64'(pad_highz), 64'd0);
        step(1'b1, 1'b0, o);
        chk("R4 R9 highz after Update-IR", 64'(pad_highz), 64'd1);
        step(1'b0, 1'b0, o);

        // R1 R2: five tms highs from Shift-DR reach Test-Logic-Reset
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, o);
        chk("R1 highz kept after four tms highs", 64'(pad_highz), 64'd1);
        step(1'b1, 1'b0, o);
        chk("R1 R2 highz cleared by tms reset", 64'(pad_highz), 64'd0);
        step(1'b0, 1'b0, o);
        din = 64'h0123_4567_89AB;
        scan(1'b0, DRN, din, dout, oe_ok);
        chk("R1 R6 identification after tms reset", dout & ((64'd1 << DRN) - 1), exp_scan(4'd2, din));

        // R2: trst_n clears a driving instruction and bsr_out
        scan(1'b1, 4, 64'(4'b0000), dout, oe_ok);
        scan(1'b0, DRN, 64'hFF_FFFF_FFFF, dout, oe_ok);
        chk("R8 bsr_out all ones", 64'(bsr_out), 64'((1 << N_OUT) - 1));
        chk("R9 drive under EXTEST", 64'(pad_drive), 64'd1);
        trst_n = 1'b0;
        step(1'b0, 1'b0, o);
        chk("R2 drive cleared by trst_n", 64'(pad_drive), 64'd0);
        chk("R2 bsr_out cleared by trst_n", 64'(bsr_out), 64'd0);
        trst_n = 1'b1;
        step(1'b0, 1'b0, o);
        chk("R10 tdo_oe idle", 64'(tdo_oe), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Bit i of the high-Z opcode 0011, LSB first.
    function automatic logic OP_HIGHZ_BIT(input int i);
        logic [3:0] v;
        v = 4'b0011;
        return v[i];
    endfunction

endmodule